// File: doc/BRIEF.md
# Cacheable Store Backup Buffer

This block keeps an ordered record of stores that allocate into cacheable memory, so that the stored values can later be pushed back out to memory or thrown away. Each record holds the full store address and the stored word. A store arriving with its cacheable flag clear leaves the buffer untouched.

There are two ways to release the contents. A discard command empties the whole buffer and sends nothing to memory. A line-invalidate command names an address. The block then walks the buffer from oldest to newest. Every entry whose address falls in the same 32-byte line is written back through a valid/ready memory write port and then removed from the buffer. Entries in other lines stay in the buffer, in their original relative order. While this walk runs, the block raises `busy` and accepts no new command.

Top module: `store_backup_buf`

## Requirements
- R1: A record request with `rec_cacheable`=1, accepted while idle, appends {address, data} at the tail. Buffer order is therefore issue order.
- R2: A record request with `rec_cacheable`=0 has no effect on the buffer.
- R3: A discard command accepted while idle empties the buffer and causes no memory write.
- R4: On a line-invalidate, an entry matches when its address with bits [4:0] cleared equals `inv_addr` with bits [4:0] cleared. The low 5 bits of `inv_addr` are ignored.
- R5: Each matching entry is written to its own full address with its saved data, oldest first, with at most one write per cycle. The entry is removed when `mem_wvalid` and `mem_wready` are both high.
- R6: Entries that do not match stay in the buffer and keep their relative order.
- R7: The buffer holds `DEPTH` (default 8) entries. A cacheable record request made while the buffer is full is dropped, and `overflow` is high for exactly the following cycle.
- R8: `busy` rises in the cycle after an accepted line-invalidate and falls once the walk reaches the end of the buffer. This holds even when no entry matches or the buffer is empty. `mem_wvalid` is high only while `busy` is high. While `mem_wready` is low, `mem_wvalid`, `mem_waddr` and `mem_wdata` hold steady.
- R9: While `busy` is high, record, discard and line-invalidate requests are ignored.
- R10: When commands arrive together while the block is idle, discard wins over line-invalidate, and line-invalidate wins over record. The losing requests have no effect.
- R11: After reset the buffer is empty, and `busy`, `mem_wvalid` and `overflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_valid | input | 1 | Record-store request |
| rec_addr | input | AW | Store address |
| rec_data | input | DW | Store data |
| rec_cacheable | input | 1 | Store address is cacheable |
| discard | input | 1 | Empty the buffer without writing |
| inv_valid | input | 1 | Line-invalidate request |
| inv_addr | input | AW | Address naming the line to write back |
| mem_wvalid | output | 1 | Memory write request |
| mem_waddr | output | AW | Memory write address |
| mem_wdata | output | DW | Memory write data |
| mem_wready | input | 1 | Memory accepts the write |
| busy | output | 1 | Line walk in progress |
| overflow | output | 1 | One-cycle pulse: a store was dropped because the buffer was full |

## Verification
Two situations are hard to reach from the ports. The first is a command arriving in the middle of a walk. The bench holds `mem_wready` low so the walk stalls on a matching entry. It then issues a cacheable record and a discard while `busy` is high. Later invalidates show whether those commands changed the buffer. The second is a walk over interleaved lines that must keep the survivors in order. The bench drives a toggling ready pattern, which makes removals and skips alternate. It then drains the remaining lines one at a time, and a scoreboard compares each write against a queue model of the buffer.

// File: rtl/sbb_pkg.sv
package sbb_pkg;
  typedef enum logic {WALK_IDLE = 1'b0, WALK_SCAN = 1'b1} walk_state_t;
endpackage

// File: rtl/sbb_store.sv
module sbb_store #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          rm,
  input  logic [IW-1:0] rm_idx,
  input  logic [CW-1:0] rd_idx,
  output logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] cnt,
  output logic          full
);
  logic [AW-1:0] slot_addr [DEPTH];
  logic [DW-1:0] slot_data [DEPTH];
  logic [CW-1:0] cnt_n;

  assign full = (cnt == CW'(DEPTH));

  always_comb begin
    cnt_n = cnt;
    if (clr)       cnt_n = '0;
    else if (push) cnt_n = cnt + 1'b1;
    else if (rm)   cnt_n = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic          wr_en;
    logic [AW-1:0] addr_n;
    logic [DW-1:0] data_n;
    always_comb begin
      wr_en  = 1'b0;
      addr_n = slot_addr[i];
      data_n = slot_data[i];
      if (push && cnt == CW'(i)) begin
        wr_en  = 1'b1;
        addr_n = push_addr;
        data_n = push_data;
      end else if (rm && rm_idx <= IW'(i)) begin
        wr_en = 1'b1;
        if (i < DEPTH - 1) begin
          addr_n = slot_addr[(i < DEPTH - 1) ? i + 1 : i];
          data_n = slot_data[(i < DEPTH - 1) ? i + 1 : i];
        end
      end
    end
    always_ff @(posedge clk) begin
      if (wr_en) begin
        slot_addr[i] <= addr_n;
        slot_data[i] <= data_n;
      end
    end
  end

  always_comb begin
    rd_addr = '0;
    rd_data = '0;
    if (rd_idx < CW'(DEPTH)) begin
      rd_addr = slot_addr[IW'(rd_idx)];
      rd_data = slot_data[IW'(rd_idx)];
    end
  end

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  // R3
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);
endmodule

// File: rtl/sbb_walk.sv
module sbb_walk
  import sbb_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int AW        = 32,
  parameter int LINE_BITS = 5,
  localparam int IW       = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] line_addr,
  input  logic [CW-1:0] cnt,
  input  logic [AW-1:0] ent_addr,
  input  logic          mem_wready,
  output logic [CW-1:0] idx,
  output logic          rm,
  output logic [IW-1:0] rm_idx,
  output logic          wvalid,
  output logic          busy
);
  walk_state_t            state, state_n;
  logic [CW-1:0]          idx_n;
  logic [AW-LINE_BITS-1:0] line_q, line_n;
  logic                   in_range, hit;

  assign busy     = (state == WALK_SCAN);
  assign in_range = (idx < cnt);
  assign hit      = busy && in_range && (ent_addr[AW-1:LINE_BITS] == line_q);
  assign wvalid   = hit;
  assign rm       = hit && mem_wready;
  assign rm_idx   = IW'(idx);

  always_comb begin
    state_n = state;
    idx_n   = idx;
    line_n  = line_q;
    case (state)
      WALK_IDLE: if (start) begin
        state_n = WALK_SCAN;
        idx_n   = '0;
        line_n  = line_addr[AW-1:LINE_BITS];
      end
      WALK_SCAN: begin
        if (!in_range)    state_n = WALK_IDLE;
        else if (!hit)    idx_n = idx + 1'b1;
      end
      default: state_n = WALK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= WALK_IDLE;
      idx    <= '0;
      line_q <= '0;
    end else begin
      state  <= state_n;
      idx    <= idx_n;
      line_q <= line_n;
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid && !mem_wready |=> wvalid && $stable(idx));
  // R5
  one_removal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rm |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/store_backup_buf.sv
module store_backup_buf #(
  parameter int DEPTH     = 8,
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int LINE_BITS = 5,
  localparam int IW       = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rec_valid,
  input  logic [AW-1:0] rec_addr,
  input  logic [DW-1:0] rec_data,
  input  logic          rec_cacheable,
  input  logic          discard,
  input  logic          inv_valid,
  input  logic [AW-1:0] inv_addr,
  output logic          mem_wvalid,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_wready,
  output logic          busy,
  output logic          overflow
);
  logic          idle, do_clr, do_start, rec_try, do_push, ovf_n;
  logic          rm, full;
  logic [IW-1:0] rm_idx;
  logic [CW-1:0] cnt, idx;

  assign idle     = !busy;
  assign do_clr   = idle && discard;
  assign do_start = idle && !discard && inv_valid;
  assign rec_try  = idle && !discard && !inv_valid && rec_valid && rec_cacheable;
  assign do_push  = rec_try && !full;
  assign ovf_n    = rec_try && full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) overflow <= 1'b0;
    else        overflow <= ovf_n;
  end

  sbb_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
    .clk, .rst_n,
    .clr(do_clr), .push(do_push), .push_addr(rec_addr), .push_data(rec_data),
    .rm, .rm_idx, .rd_idx(idx), .rd_addr(mem_waddr), .rd_data(mem_wdata),
    .cnt, .full
  );

  sbb_walk #(.DEPTH(DEPTH), .AW(AW), .LINE_BITS(LINE_BITS)) u_walk (
    .clk, .rst_n,
    .start(do_start), .line_addr(inv_addr), .cnt, .ent_addr(mem_waddr),
    .mem_wready, .idx, .rm, .rm_idx, .wvalid(mem_wvalid), .busy
  );

  // R8
  wvalid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid |-> busy);
  // R8
  stall_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid && !mem_wready |=> $stable(mem_waddr) && $stable(mem_wdata));
  // R9
  busy_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !(mem_wvalid && mem_wready) |=> $stable(cnt));
  // R2
  uncached_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !discard && !inv_valid && rec_valid && !rec_cacheable |=> $stable(cnt));
  // R7
  overflow_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> $past(cnt) == CW'(DEPTH) && $stable(cnt));
endmodule

// File: tb/store_backup_buf_tb.sv
`timescale 1ns/1ps
module store_backup_buf_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rec_valid, rec_cacheable, discard, inv_valid, mem_wready;
  logic [31:0] rec_addr, rec_data, inv_addr;
  logic        mem_wvalid, busy, overflow;
  logic [31:0] mem_waddr, mem_wdata;

  int n_chk = 0, n_fail = 0;
  int rdy_mode = 0;
  logic [63:0] model_q[$];
  logic [63:0] exp_q[$];

  always #5 clk = ~clk;

  store_backup_buf u_dut (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ready pattern: 0 always ready, 1 held low, 2 toggling
  always @(posedge clk) begin
    #1;
    case (rdy_mode)
      0: mem_wready = 1'b1;
      1: mem_wready = 1'b0;
      default: mem_wready = ~mem_wready;
    endcase
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && mem_wvalid && mem_wready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected write", {mem_waddr, mem_wdata}, 64'h0);
      end else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        check({mem_waddr, mem_wdata} == e, "R5 write order/payload", {mem_waddr, mem_wdata}, e);
      end
    end
  end

  task automatic cyc(input bit rv, input logic [31:0] ra, input logic [31:0] rd, input bit rc,
                     input bit dc, input bit iv, input logic [31:0] ia);
    bit idle_now, ovf_exp;
    @(posedge clk); #1;
    rec_valid = rv; rec_addr = ra; rec_data = rd; rec_cacheable = rc;
    discard = dc; inv_valid = iv; inv_addr = ia;
    idle_now = !busy;
    ovf_exp = 1'b0;
    if (idle_now) begin
      if (dc) model_q.delete();
      else if (iv) begin
        for (int i = 0; i < model_q.size(); i++) begin
          if (model_q[i][63:37] == ia[31:5]) begin
            exp_q.push_back(model_q[i]);
            model_q.delete(i);
            i--;
          end
        end
      end else if (rv && rc) begin
        if (model_q.size() < 8) model_q.push_back({ra, rd});
        else ovf_exp = 1'b1;
      end
    end
    @(posedge clk); #1;
    rec_valid = 0; discard = 0; inv_valid = 0;
    if (rv) check(overflow == ovf_exp, "R7 overflow pulse", 64'(overflow), 64'(ovf_exp));
    if (idle_now && iv && !dc) check(busy == 1'b1, "R8 busy after invalidate", 64'(busy), 64'h1);
  endtask

  task automatic rec(input logic [31:0] a, input logic [31:0] d, input bit c = 1'b1);
    cyc(1'b1, a, d, c, 1'b0, 1'b0, '0);
  endtask

  task automatic wait_idle(input string req);
    while (busy) begin @(posedge clk); #1; end
    check(exp_q.size() == 0, req, 64'(exp_q.size()), 64'h0);
  endtask

  task automatic inv(input logic [31:0] a, input string req);
    cyc(1'b0, '0, '0, 1'b0, 1'b0, 1'b1, a);
    wait_idle(req);
  endtask

  initial begin
    #(200000 * 10);
    check(1'b0, "watchdog", 64'h0, 64'h1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; rec_valid = 0; rec_addr = 0; rec_data = 0; rec_cacheable = 0;
    discard = 0; inv_valid = 0; inv_addr = 0; mem_wready = 1;
    repeat (3) @(posedge clk);
    #1;
    // R11
    check(!busy && !mem_wvalid && !overflow, "R11 reset outputs", {busy, mem_wvalid, overflow}, 0);
    rst_n = 1;
    @(posedge clk); #1;
    inv(32'h0000_1000, "R11 empty after reset");

    // R1 R2 R4 R5: mixed lines, uncached store skipped, offset bits in inv_addr
    rec(32'h1000, 32'hA0);
    rec(32'h1004, 32'hA1);
    rec(32'h1008, 32'hFF, 1'b0);
    rec(32'h1020, 32'hB0);
    rec(32'h101C, 32'hA2);
    rec(32'h1010, 32'hA3);
    inv(32'h0000_1011, "R4 line match drained");
    inv(32'h0000_1000, "R5 entries removed");
    inv(32'h0000_103F, "R6 other line kept");

    // R6 interleaved lines under toggling ready
    rec(32'h2020, 32'hB1);
    rec(32'h2000, 32'hA1);
    rec(32'h2024, 32'hB2);
    rec(32'h2004, 32'hA2);
    rec(32'h2040, 32'hC1);
    rdy_mode = 2;
    inv(32'h2000, "R6 toggled drain");
    rdy_mode = 0;
    inv(32'h2020, "R6 survivors in order");
    // R3 discard
    cyc(1'b0, '0, '0, 1'b0, 1'b1, 1'b0, '0);
    inv(32'h2040, "R3 discard wrote nothing");

    // R7 overflow
    for (int i = 0; i < 9; i++) rec(32'h3000 + 32'(i * 4), 32'h300 + 32'(i));
    rec(32'h3FFF_0000, 32'hDEAD, 1'b0);
    inv(32'h3000, "R7 only eight kept");

    // R9 commands during a stalled walk
    rec(32'h4000, 32'hD0);
    rec(32'h4008, 32'hD1);
    rdy_mode = 1;
    cyc(1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 32'h4000);
    repeat (3) @(posedge clk);
    #1;
    check(busy && mem_wvalid && mem_waddr == 32'h4000, "R8 stalled write held",
          {mem_wvalid, mem_waddr}, {1'b1, 32'h4000});
    cyc(1'b1, 32'h4010, 32'hD9, 1'b1, 1'b0, 1'b0, '0);
    cyc(1'b0, '0, '0, 1'b0, 1'b1, 1'b0, '0);
    cyc(1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 32'h5000);
    rdy_mode = 0;
    wait_idle("R9 commands ignored while busy");
    inv(32'h4000, "R9 no late record");

    // R10 priorities
    rec(32'h6000, 32'hE0);
    cyc(1'b1, 32'h6004, 32'hE1, 1'b1, 1'b1, 1'b1, 32'h6000);
    inv(32'h6000, "R10 discard wins");
    rec(32'h6008, 32'hE3);
    cyc(1'b1, 32'h600C, 32'hE4, 1'b1, 1'b0, 1'b1, 32'h6000);
    wait_idle("R10 invalidate wins");
    inv(32'h6000, "R10 record dropped");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule